// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous burst SRAM. Each word is 36 bits wide, made of four 9-bit lanes (8 data bits plus 1 parity bit). The array depth is set by a parameter. All address and control inputs are sampled on the rising clock edge. A burst begins when either of two active-low address strobes is asserted: the processor-side strobe or the controller-side strobe. After that, an internal 2-bit counter steps the low address bits each time the advance input is asserted. The counter follows either linear order or interleaved order, and the order-select input is sampled one cycle before it takes effect.

Read data moves through two register stages: an access register and an output register. The data therefore appears on the port two clock edges after the address was sampled. Writes take place at the edge that follows the access register. A write can cover all lanes (global write) or only the lanes picked by individual lane strobes. Three chip selects with mixed polarity gate each new burst. A start strobe seen while the chip is not selected ends the current burst, and the output stops driving after one cycle. An asynchronous output enable gates the read drive with no clock needed. A sleep input blocks every access.

Top module: `burst_sram`

## Requirements
- R1: A read sampled at clock edge k is driven on `rd_data`, with `rd_drive` high, after edge k+1, provided `out_en_n` is low.
- R2: A burst loads `addr_i` when `strobe_ctl_n` is low, or when `strobe_cpu_n` and `sel1_n` are both low, and only while the chip is selected. A load through `strobe_cpu_n` is always a read, even if write controls are active in that cycle.
- R3: With `order_sel` = 0 (linear), beat n of a burst uses low address bits (base + n) mod 4. The upper address bits keep the base value for the whole burst.
- R4: With `order_sel` = 1 (interleaved), beat n of a burst uses low address bits equal to base XOR n.
- R5: In a burst cycle with no start strobe and `advance_n` high, the previous address is accessed again.
- R6: The burst order used at a given edge is the one set by `order_sel` at the previous edge.
- R7: The chip is selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. A start strobe seen while the chip is not selected performs no access and ends the burst. No access follows until a new load.
- R8: One edge after a deselect, an idle cycle or a write is sampled, `rd_drive` is low and `rd_data` is zero.
- R9: When `all_wr_n`=0, all four lanes are written. Otherwise, when `lane_wr_en_n`=0, lane i (bits 9i+8..9i, lane a = 0) is written when `lane_wr_n[i]`=0. A write performs no read.
- R10: While `out_en_n` is high, `rd_drive` is low and `rd_data` is zero, regardless of the clock.
- R11: While `sleep` is high, no access happens: memory is left unchanged and nothing is driven. Sleep also ends the current burst.
- R12: After reset, `rd_drive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Burst base address |
| strobe_cpu_n | input | 1 | Processor-side burst start, active low, gated by sel1_n |
| strobe_ctl_n | input | 1 | Controller-side burst start, active low |
| advance_n | input | 1 | Burst advance, active low |
| sel1_n | input | 1 | Chip select 1, active low |
| sel2 | input | 1 | Chip select 2, active high |
| sel3_n | input | 1 | Chip select 3, active low |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| lane_wr_en_n | input | 1 | Lane write enable, active low |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Power-down; blocks all accesses |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wr_data | input | LANES*LANE_W | Write data |
| rd_data | output | LANES*LANE_W | Read data, zero when not driven |
| rd_drive | output | 1 | High while the output bus is driven |

## Verification
Every cycle's inputs produce one result, and that result reaches the ports two rising edges later (R1, R8). The bench applies stimulus at the falling edge and computes that cycle's access in its own model. It keeps the expected read in a one-entry delay slot and compares the slot at the next falling edge, which is after the output register has loaded. Writes update the model memory at once, so a read in any later cycle sees the new data, just as the array does. The output enable (R10) is checked between edges, 1 ns after it toggles, to confirm that it acts without a clock.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  // Low two address bits of a burst beat
  function automatic logic [1:0] beat_low(input logic [1:0] base,
                                          input logic [1:0] beat,
                                          input burst_order_e ord);
    return (ord == ORD_INTERLEAVE) ? (base ^ beat) : (base + beat);
  endfunction

endpackage

// File: rtl/burst_sram_seq.sv
module burst_sram_seq
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strobe_cpu_n,
  input  logic              strobe_ctl_n,
  input  logic              advance_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              all_wr_n,
  input  logic              lane_wr_en_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              order_sel,
  input  logic              sleep,
  input  logic [DATA_W-1:0] wr_data,
  output logic              acc_vld,
  output logic [LANES-1:0]  acc_mask,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_wdata
);

  logic              selected, cpu_load, start;
  logic              active_q, active_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        beat_q, beat_d;
  burst_order_e      order_q;
  logic              go;
  logic [LANES-1:0]  lane_mask, wmask;
  logic [ADDR_W-1:0] cur_addr;

  assign selected = !sel1_n && sel2 && !sel3_n;
  assign cpu_load = !strobe_cpu_n && !sel1_n;
  assign start    = cpu_load || !strobe_ctl_n;

  always_comb begin
    active_d = active_q;
    base_d   = base_q;
    beat_d   = beat_q;
    go       = 1'b0;
    if (sleep) begin
      active_d = 1'b0;
    end else if (start) begin
      if (selected) begin
        active_d = 1'b1;
        base_d   = addr_i;
        beat_d   = 2'd0;
        go       = 1'b1;
      end else begin
        active_d = 1'b0;
      end
    end else if (active_q) begin
      go = 1'b1;
      if (!advance_n) beat_d = beat_q + 2'd1;
    end
    cur_addr = {base_d[ADDR_W-1:2], beat_low(base_d[1:0], beat_d, order_q)};
  end

  always_comb begin
    if (!all_wr_n)          lane_mask = '1;
    else if (!lane_wr_en_n) lane_mask = ~lane_wr_n;
    else                    lane_mask = '0;
    wmask = cpu_load ? '0 : lane_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      base_q    <= '0;
      beat_q    <= '0;
      order_q   <= ORD_LINEAR;
      acc_vld   <= 1'b0;
      acc_mask  <= '0;
      acc_addr  <= '0;
      acc_wdata <= '0;
    end else begin
      active_q  <= active_d;
      base_q    <= base_d;
      beat_q    <= beat_d;
      order_q   <= burst_order_e'(order_sel);
      acc_vld   <= go;
      acc_mask  <= go ? wmask : '0;
      acc_addr  <= cur_addr;
      acc_wdata <= wr_data;
    end
  end

  // R11
  sleep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sleep) |-> !acc_vld);

  // R7
  unsel_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start && !selected && !sleep) |-> !acc_vld);

  // R3
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !start && !sleep) |=> acc_addr[ADDR_W-1:2] == $past(base_q[ADDR_W-1:2]));

endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_vld,
  input  logic [LANES-1:0]  acc_mask,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data
);

  logic is_read;
  assign is_read = acc_vld && (acc_mask == '0);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (acc_vld && acc_mask[g])
        lane_mem[acc_addr] <= acc_wdata[g*LANE_W +: LANE_W];
      if (is_read)
        out_data[g*LANE_W +: LANE_W] <= lane_mem[acc_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= is_read;
  end

  // R9
  wr_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_vld && (acc_mask != '0)) |-> !out_vld);

  // R8
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!acc_vld) |-> !out_vld);

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strobe_cpu_n,
  input  logic              strobe_ctl_n,
  input  logic              advance_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              all_wr_n,
  input  logic              lane_wr_en_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              order_sel,
  input  logic              sleep,
  input  logic              out_en_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive
);

  logic              acc_vld, out_vld;
  logic [LANES-1:0]  acc_mask;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_wdata, out_data;

  burst_sram_seq #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .advance_n(advance_n),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_wr_n(lane_wr_n),
    .order_sel(order_sel), .sleep(sleep), .wr_data(wr_data),
    .acc_vld(acc_vld), .acc_mask(acc_mask), .acc_addr(acc_addr), .acc_wdata(acc_wdata)
  );

  burst_sram_core #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) core_i (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_mask(acc_mask),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .out_vld(out_vld), .out_data(out_data)
  );

  assign rd_drive = out_vld && !out_en_n;
  assign rd_data  = rd_drive ? out_data : '0;

endmodule

// File: tb/burst_sram_tb_top.sv
`timescale 1ns/1ps
module burst_sram_tb_top;

  localparam int AW = 8;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1, advance_n = 1'b1;
  logic          sel1_n = 1'b0, sel2 = 1'b1, sel3_n = 1'b0;
  logic          all_wr_n = 1'b1, lane_wr_en_n = 1'b1;
  logic [3:0]    lane_wr_n = 4'hf;
  logic          order_sel = 1'b0, sleep = 1'b0, out_en_n = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_drive;

  always #2 clk = ~clk;

  burst_sram dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .advance_n(advance_n),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_wr_n(lane_wr_n),
    .order_sel(order_sel), .sleep(sleep), .out_en_n(out_en_n), .wr_data(wr_data),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  string tag = "R12";

  // bench model state
  logic [DW-1:0] mm [256];
  logic          m_act = 0, m_mode = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;
  logic          prev_rd = 0;
  logic [DW-1:0] prev_d = '0;

  task automatic check(input string t, input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic model(output logic rd, output logic [DW-1:0] d);
    logic sel, cpu, st, acc;
    logic [1:0] lo;
    logic [3:0] msk;
    logic [AW-1:0] a;
    sel = !sel1_n && sel2 && !sel3_n;
    cpu = !strobe_cpu_n && !sel1_n;
    st  = cpu || !strobe_ctl_n;
    acc = 0;
    if (sleep) m_act = 0;
    else if (st) begin
      if (sel) begin m_act = 1; m_base = addr_i; m_beat = 0; acc = 1; end
      else m_act = 0;
    end else if (m_act) begin
      acc = 1;
      if (!advance_n) m_beat = m_beat + 2'd1;
    end
    lo  = m_mode ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
    a   = {m_base[AW-1:2], lo};
    msk = !all_wr_n ? 4'hf : (!lane_wr_en_n ? ~lane_wr_n : 4'h0);
    if (cpu) msk = 4'h0;
    rd = acc && (msk == 4'h0);
    d  = mm[a];
    if (acc)
      for (int i = 0; i < 4; i++)
        if (msk[i]) mm[a][i*9 +: 9] = wr_data[i*9 +: 9];
    m_mode = order_sel;
  endtask

  task automatic step();
    logic rd;
    logic [DW-1:0] d;
    logic exp_drv;
    model(rd, d);
    @(posedge clk);
    @(negedge clk);
    exp_drv = prev_rd && !out_en_n;
    check(tag, {rd_drive, rd_data}, {exp_drv, exp_drv ? prev_d : {DW{1'b0}}});
    prev_rd = rd;
    prev_d  = d;
  endtask

  task automatic idle();
    strobe_cpu_n = 1; strobe_ctl_n = 1; advance_n = 1;
    sel1_n = 0; sel2 = 1; sel3_n = 0;
    all_wr_n = 1; lane_wr_en_n = 1; lane_wr_n = 4'hf;
    sleep = 0; out_en_n = 0;
  endtask

  task automatic load_ctl(input logic [AW-1:0] a);
    idle(); strobe_ctl_n = 0; addr_i = a; step(); idle();
  endtask

  task automatic deselect();
    idle(); strobe_ctl_n = 0; sel2 = 0; step(); idle();
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R12", {rd_drive, rd_data}, {1'b0, {DW{1'b0}}});
    rst_n = 1;
    @(negedge clk);

    // R9 global write preload of every word
    tag = "R9";
    for (int a = 0; a < 256; a++) begin
      idle(); strobe_ctl_n = 0; addr_i = a[AW-1:0]; all_wr_n = 0;
      wr_data = {a[7:0], 8'h5a, ~a[7:0], 4'h3, a[7:0]};
      step();
    end
    deselect();

    // R1 single read then deselect
    tag = "R1";
    load_ctl(8'd17); step(); deselect(); step();

    // R8 deselect after read drops drive in one cycle
    tag = "R8";
    load_ctl(8'd40); deselect(); step();

    // R2 processor strobe ignores write controls; priority over controller strobe
    tag = "R2";
    idle(); strobe_cpu_n = 0; strobe_ctl_n = 0; addr_i = 8'd33; all_wr_n = 0; wr_data = '1;
    step(); idle(); deselect();
    load_ctl(8'd33); deselect();
    idle(); strobe_cpu_n = 0; sel1_n = 1; strobe_ctl_n = 1; addr_i = 8'd50; step(); step();

    // R3 linear burst from base 6
    tag = "R3";
    order_sel = 0; idle(); step();
    load_ctl(8'd6);
    for (int i = 0; i < 4; i++) begin advance_n = 0; step(); end
    deselect();

    // R4 interleaved burst from base 6
    tag = "R4";
    order_sel = 1; idle(); deselect();
    load_ctl(8'd6);
    for (int i = 0; i < 4; i++) begin advance_n = 0; step(); end
    deselect();

    // R5 suspend keeps address
    tag = "R5";
    load_ctl(8'd9); advance_n = 0; step(); advance_n = 1; step(); step(); deselect();

    // R6 order change mid-burst takes one cycle
    tag = "R6";
    order_sel = 0; idle(); deselect();
    load_ctl(8'd5); advance_n = 0; order_sel = 1; step(); advance_n = 0; step(); step();
    deselect(); order_sel = 0;

    // R7 unselected start ends burst
    tag = "R7";
    load_ctl(8'd70); idle(); strobe_ctl_n = 0; sel3_n = 1; step(); idle();
    advance_n = 0; step(); step(); idle(); sel1_n = 1; strobe_ctl_n = 0; step(); idle(); step();

    // R9 lane write of lanes a and c
    tag = "R9";
    idle(); strobe_ctl_n = 0; addr_i = 8'd88; lane_wr_en_n = 0; lane_wr_n = 4'b1010;
    wr_data = 36'h1_2345_6789; step(); idle(); deselect();
    load_ctl(8'd88); deselect();

    // R10 asynchronous output enable
    tag = "R10";
    load_ctl(8'd90); step();
    #1 out_en_n = 1; #1;
    check("R10", {rd_drive, rd_data}, {1'b0, {DW{1'b0}}});
    out_en_n = 0; #0.5;
    check("R10", {rd_drive, rd_data}, {1'b1, mm[8'd90]});
    @(negedge clk); prev_rd = 1; prev_d = mm[8'd90];
    deselect();

    // R11 sleep blocks a write and ends the burst
    tag = "R11";
    load_ctl(8'd120); idle(); sleep = 1; strobe_ctl_n = 0; all_wr_n = 0; wr_data = '0;
    addr_i = 8'd120; step(); idle(); step(); load_ctl(8'd120); deselect();

    // R1 constrained random traffic
    tag = "R1";
    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      r = $urandom;
      strobe_ctl_n = (r[2:0] != 0);
      strobe_cpu_n = (r[5:3] != 0);
      advance_n    = r[6];
      sel1_n       = (r[10:7] == 0);
      sel2         = (r[10:7] != 1);
      sel3_n       = (r[10:7] == 2);
      all_wr_n     = (r[13:11] != 0);
      lane_wr_en_n = (r[15:14] != 0);
      lane_wr_n    = r[19:16];
      if (r[24:20] == 0) order_sel = ~order_sel;
      sleep        = (r[29:25] == 0);
      out_en_n     = (r[31:30] == 0) && r[6];
      addr_i       = $urandom;
      wr_data      = {$urandom, $urandom};
      step();
    end
    idle(); deselect(); step();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule